// File: doc/BRIEF.md
# Synchronous Byte-Write SRAM Core

This block is a clocked single-port memory. Each word holds 32 data bits and 4 parity bits, organised as four 9-bit lanes. Each lane has one data byte and its own parity bit. A word address is sampled on every rising clock edge. At that same edge the block either writes the word, or fetches it into an output register.

A write is either global or per byte. A global-write strobe stores all 36 bits. A byte write needs a byte-write enable together with one or more active-low lane selects. Read data appears for the whole cycle after the edge that sampled its address. An output-valid flag stands in for the three-state control of a bidirectional bus. The flag drops when the output enable is high, in the cycle that follows a write, and while the snooze input is high. While the flag is low, the data-out ports read as zero. While snooze is high, clock edges have no effect and the stored words are kept.

The address width is a parameter. At `ADDR_W = 16` the core holds the full 64K words. The default is smaller so that the memory elaborates quickly.

Top module: `sram_core`

## Requirements
- R1: The core stores 2**ADDR_W words of 36 bits. Word layout:
  - Lane n is din[8n+7:8n] plus din_par[n].
  - Every address, including the highest (2**ADDR_W-1), keeps its value until it is written again.
- R2: When gw_n is low at a rising edge (and zz is low), all four lanes at addr are written from din and din_par. The values of bwe_n and bw_n make no difference.
- R3: When gw_n is high and bwe_n is low at a rising edge, every lane n with bw_n[n] low is written. Lanes whose select is high keep their old contents.
- R4: At a rising edge that samples no write, the word at addr is fetched. It is shown on dout/dout_par with dout_vld high for the following cycle, provided oe_n and zz allow it.
- R5: While oe_n is high, dout_vld is 0 and dout and dout_par are 0, with no clock edge needed.
- R6: In the cycle after any rising edge that sampled a write, dout_vld is 0 and the data ports are 0.
- R7: While zz is high:
  - dout_vld is 0.
  - Rising edges neither write nor fetch, so the memory and the output register are unchanged.
- R8: After zz falls, the next rising edge operates normally and all earlier contents are intact. Before that edge, the word fetched before snooze is shown again.
- R9: A cycle with gw_n high and either bwe_n high or bw_n all ones is a read. No lane is written.
- R10: While rst_n is low, the output register and the write flag are cleared, so dout reads 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of output state |
| addr | input | ADDR_W | Word address, sampled at each edge |
| din | input | 32 | Write data bytes |
| din_par | input | 4 | Write parity bits, one per lane |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Lane selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| zz | input | 1 | Snooze, active high, asynchronous gate |
| dout | output | 32 | Read data bytes, 0 when not valid |
| dout_par | output | 4 | Read parity bits, 0 when not valid |
| dout_vld | output | 1 | Outputs would be driven |

## Verification
Two kinds of internal fault show up at the ports. A wrong lane mask corrupts a single byte or parity bit. A wrong fetch decision leaves a stale word in the output register. In both cases the error appears on the first later read of that address, or in the very next cycle for the output register. A stuck write flag or snooze gate shows up one cycle after the edge, as a dout_vld value that disagrees with the reference model. To expose these faults, the bench first fills every location through global writes. It then mixes byte writes, reads, disabled cycles and snooze periods, and compares every output on every clock.

// File: rtl/sram_core.sv
module sram_core #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8*LANES-1:0]   din,
  input  logic [LANES-1:0]     din_par,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [LANES-1:0]     bw_n,
  input  logic                 oe_n,
  input  logic                 zz,
  output logic [8*LANES-1:0]   dout,
  output logic [LANES-1:0]     dout_par,
  output logic                 dout_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0]      lane_we;
  logic                  wr_now;
  logic                  wr_q;
  logic [LANES-1:0][8:0] lane_q;

  assign lane_we  = {LANES{~gw_n}} | ({LANES{~bwe_n}} & ~bw_n);
  assign wr_now   = |lane_we;
  assign dout_vld = ~oe_n & ~wr_q & ~zz;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   wr_q <= 1'b0;
    else if (!zz) wr_q <= wr_now;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [8:0] arr [DEPTH];

    always_ff @(posedge clk)
      if (!zz && lane_we[g]) arr[addr] <= {din_par[g], din[8*g +: 8]};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                lane_q[g] <= '0;
      else if (!zz && !wr_now)   lane_q[g] <= arr[addr];

    assign dout[8*g +: 8] = dout_vld ? lane_q[g][7:0] : 8'h00;
    assign dout_par[g]    = dout_vld & lane_q[g][8];
  end
endmodule

module sram_core_chk #(
  parameter int LANES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  gw_n,
  input logic                  bwe_n,
  input logic [LANES-1:0]      bw_n,
  input logic                  oe_n,
  input logic                  zz,
  input logic [8*LANES-1:0]    dout,
  input logic [LANES-1:0]      dout_par,
  input logic                  dout_vld,
  input logic [LANES-1:0][8:0] lane_q
);
  // R5
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_vld && dout == '0 && dout_par == '0));

  // R6
  wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && (!gw_n || (!bwe_n && bw_n != '1))) |=> !dout_vld);

  // R7
  zz_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz |-> !dout_vld);

  // R7
  zz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> $stable(lane_q));

  // R9
  rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && gw_n && (bwe_n || bw_n == '1)) |=> (dout_vld == (!oe_n && !zz)));
endmodule

bind sram_core sram_core_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
  .oe_n(oe_n), .zz(zz), .dout(dout), .dout_par(dout_par),
  .dout_vld(dout_vld), .lane_q(lane_q)
);

// File: tb/sram_core_bench.sv
`timescale 1ns/1ps
module sram_core_bench;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] din = '0;
  logic [3:0]  din_par = '0;
  logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1, zz = 1'b0;
  logic [3:0] bw_n = 4'hF;
  logic [31:0] dout;
  logic [3:0]  dout_par;
  logic dout_vld;

  always #4 clk = ~clk;

  sram_core #(.ADDR_W(AW), .LANES(4)) u_sram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .din_par(din_par),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz),
    .dout(dout), .dout_par(dout_par), .dout_vld(dout_vld));

  bit [35:0] mem [DEPTH];
  bit [35:0] mq = '0;
  bit mwr = 1'b0;
  int checks = 0, fails = 0;
  bit [31:0] lfsr = 32'h1ACE_B00C;

  function automatic bit [35:0] pat(int a);
    return {4'(a) ^ 4'h9, 32'h5A00_00C3 ^ (32'(a) * 32'h0101_0107)};
  endfunction

  task automatic check(string tag);
    bit ev;
    bit [31:0] ed;
    bit [3:0] ep;
    ev = !oe_n && !mwr && !zz;
    ed = ev ? mq[31:0] : 32'h0;
    ep = ev ? mq[35:32] : 4'h0;
    checks++;
    if (dout_vld !== ev || dout !== ed || dout_par !== ep) begin
      fails++;
      $display("FAIL %s vld=%b dout=%h par=%h exp vld=%b dout=%h par=%h",
               tag, dout_vld, dout, dout_par, ev, ed, ep);
    end
  endtask

  task automatic cyc(string tag, bit g, bit be, bit [3:0] bw, int a,
                     bit [35:0] d, bit oe, bit z);
    bit w;
    @(negedge clk);
    gw_n = g; bwe_n = be; bw_n = bw; addr = AW'(a);
    din = d[31:0]; din_par = d[35:32]; oe_n = oe; zz = z;
    #1 check(tag);
    @(posedge clk);
    if (!rst_n) begin mq = '0; mwr = 1'b0; end
    else if (!z) begin
      w = !g || (!be && bw != 4'hF);
      if (w) begin
        for (int i = 0; i < 4; i++)
          if (!g || !bw[i]) begin
            mem[a][8*i +: 8] = d[8*i +: 8];
            mem[a][32+i] = d[32+i];
          end
      end else mq = mem[a];
      mwr = w;
    end
  endtask

  task automatic rd(string tag, int a);
    cyc(tag, 1, 1, 4'hF, a, '0, 0, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R10 reset state
    cyc("R10", 1, 1, 4'hF, 0, '0, 1, 0);
    cyc("R10", 1, 1, 4'hF, 0, '0, 0, 0);
    #1 check("R10");
    @(negedge clk); rst_n = 1'b1;
    // R2 global fill ignoring byte controls
    for (int a = 0; a < DEPTH; a++)
      cyc("R2", 0, a[0], 4'(a), a, pat(a), 0, 0);
    // R4 / R1 reads incl. top address
    for (int a = 0; a < 16; a++) rd("R4", a * 37 % DEPTH);
    rd("R1", DEPTH - 1);
    rd("R1", 0);
    rd("R1", DEPTH - 1);
    // R3 byte writes with different lane masks
    for (int m = 0; m < 16; m++) begin
      cyc("R3", 1, 0, 4'(m), 100 + m, {4'hF, 32'hDEAD_BEEF} ^ 36'(m), 0, 0);
      rd("R3", 100 + m);
    end
    // R9 cycles classified as reads
    cyc("R9", 1, 1, 4'h0, 200, 36'h0_1111_1111, 0, 0);
    cyc("R9", 1, 0, 4'hF, 201, 36'h0_2222_2222, 0, 0);
    rd("R9", 200);
    rd("R9", 201);
    // R5 output enable off during reads
    rd("R5", 300);
    cyc("R5", 1, 1, 4'hF, 301, '0, 1, 0);
    cyc("R5", 1, 1, 4'hF, 302, '0, 1, 0);
    rd("R5", 303);
    // R6 back-to-back writes then read
    cyc("R6", 0, 1, 4'hF, 400, 36'hA_0000_0001, 0, 0);
    cyc("R6", 1, 0, 4'hE, 401, 36'hB_0000_0002, 0, 0);
    rd("R6", 400);
    rd("R6", 401);
    rd("R6", 401);
    // R7 snooze: writes attempted while asleep
    rd("R7", 500);
    cyc("R7", 0, 0, 4'h0, 500, 36'h0_0BAD_0BAD, 0, 1);
    cyc("R7", 0, 0, 4'h0, 501, 36'h0_0BAD_0BAD, 0, 1);
    cyc("R7", 1, 1, 4'hF, 502, '0, 0, 1);
    // R8 resume
    rd("R8", 500);
    rd("R8", 501);
    rd("R8", 502);
    // mixed traffic
    for (int i = 0; i < 2000; i++) begin
      int op;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = int'(lfsr[2:0]);
      cyc(op == 7 ? "R7" : op == 6 ? "R5" : op < 2 ? "R3" : "R4",
          !(op == 0), !(op == 1), lfsr[11:8], int'(lfsr[31:22]),
          {lfsr[7:4], lfsr ^ 32'h3C3C_3C3C}, op == 6, op == 7);
    end
    rd("R8", 0);
    rd("R1", DEPTH - 1);
    summary();
    $finish;
  end
endmodule